// File: doc/BRIEF.md
# Pipelined Parallel-Prefix Adder

This block adds two 32-bit operands and a carry-in and returns a 32-bit sum and a carry-out. The carries come from a Kogge-Stone prefix tree: per-bit generate and propagate terms are combined over five levels. At level l, each position merges with the position 2^(l-1) bits below it. Every group term is built in parallel, and no node drives more than two cells in the next level.

A register cuts the tree after its third level. The first stage forms the bit terms and runs three combining levels. The second stage runs the last two levels, merges the carry-in and forms the sum. A new operand pair can enter on every clock, and its result appears two clocks later. A valid flag travels with each pair. The data registers load only when their stage holds a valid pair, and reset never clears them. Only the valid flags are cleared.

Top module: `ks_pipe_adder`

## Requirements
- R1: When `valid_o` is high, `sum_o` equals (a + b + cin) mod 2^32 for the operands presented with `valid_i` high two rising edges earlier.
- R2: When `valid_o` is high, `cout_o` equals bit 32 of the 33-bit total a + b + cin of that same pair.
- R3: The carry-in enters at bit position 0. Each sum bit i equals a[i] XOR b[i] XOR the carry out of bit i-1, and the carry into bit 0 is `cin_i`. For example, all-ones plus zero with `cin_i` = 1 gives sum 0 and carry-out 1.
- R4: `valid_o` is a copy of `valid_i` delayed by exactly two rising clock edges.
- R5: Pairs presented on consecutive cycles produce results on consecutive cycles, in the same order, with no gaps.
- R6: While `rst_ni` is low, both valid flags clear asynchronously and `valid_o` reads 0. After reset is released, `valid_o` stays 0 until a pair presented after the release has had two edges to arrive.
- R7: A cycle with `valid_i` low produces a cycle with `valid_o` low two edges later. The results on either side of that gap are unaffected.
- R8: `sum_o` and `cout_o` keep the last valid result while no new valid result arrives. This holds through gaps and through a reset, because the data registers are not reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset of the valid flags |
| valid_i | input | 1 | Operand pair on `a_i`, `b_i`, `cin_i` is valid |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| cin_i | input | 1 | Carry-in |
| sum_o | output | 32 | Sum, registered |
| cout_o | output | 1 | Carry-out, registered |
| valid_o | output | 1 | `sum_o` and `cout_o` hold a new result |

## Verification
Every result, together with its valid flag, is due on the second rising edge after the pair is driven. The bench therefore drives on a falling edge and reads the outputs two falling edges later, before it drives the next pair. This keeps the stimulus for a cycle and the check of the result that belongs to it in the same loop step. The same two-edge offset sets where gaps must show as `valid_o` low while the sum holds. Reset is checked from the first falling edge while it is asserted, and again over the two falling edges after its release.

// File: rtl/ks_pkg.sv
package ks_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // merge an upper group with the adjacent lower group
  function automatic gp_t black_cell(logic g_hi, logic p_hi, logic g_lo, logic p_lo);
    gp_t r;
    r.g = g_hi | (p_hi & g_lo);
    r.p = p_hi & p_lo;
    return r;
  endfunction

endpackage

// File: rtl/ks_bitgen.sv
module ks_bitgen #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] g_o,
  output logic [WIDTH-1:0] p_o
);
  assign g_o = a_i & b_i;
  assign p_o = a_i ^ b_i;
endmodule

// File: rtl/ks_prefix_span.sv
module ks_prefix_span #(
  parameter int WIDTH     = 32,
  parameter int LVL_FIRST = 1,
  parameter int LVL_LAST  = 3
) (
  input  logic [WIDTH-1:0] g_i,
  input  logic [WIDTH-1:0] p_i,
  output logic [WIDTH-1:0] g_o,
  output logic [WIDTH-1:0] p_o
);
  localparam int NSPAN = LVL_LAST - LVL_FIRST + 1;

  logic [NSPAN:0][WIDTH-1:0] g_s;
  logic [NSPAN:0][WIDTH-1:0] p_s;

  assign g_s[0] = g_i;
  assign p_s[0] = p_i;

  for (genvar j = 0; j < NSPAN; j++) begin : g_lvl
    localparam int DIST = 1 << (LVL_FIRST + j - 1);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i < DIST) begin : g_pass
        assign g_s[j+1][i] = g_s[j][i];
        assign p_s[j+1][i] = p_s[j][i];
      end else begin : g_cell
        ks_pkg::gp_t res;
        assign res = ks_pkg::black_cell(g_s[j][i], p_s[j][i],
                                        g_s[j][i-DIST], p_s[j][i-DIST]);
        assign g_s[j+1][i] = res.g;
        assign p_s[j+1][i] = res.p;
      end
    end
  end

  assign g_o = g_s[NSPAN];
  assign p_o = p_s[NSPAN];
endmodule

// File: rtl/ks_sum_gen.sv
module ks_sum_gen #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] grp_g_i,
  input  logic [WIDTH-1:0] grp_p_i,
  input  logic [WIDTH-1:0] half_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] carry;

  // carry-in is merged after the tree: c[i] = G(i:0) | P(i:0) & cin
  assign carry  = grp_g_i | (grp_p_i & {WIDTH{cin_i}});
  assign sum_o  = half_i ^ {carry[WIDTH-2:0], cin_i};
  assign cout_o = carry[WIDTH-1];
endmodule

// File: rtl/ks_pipe_adder.sv
module ks_pipe_adder #(
  parameter int WIDTH = 32,
  parameter int SPLIT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             valid_o
);
  localparam int LEVELS = $clog2(WIDTH);

  // stage 1
  logic [WIDTH-1:0] bit_g, bit_p;
  logic [WIDTH-1:0] mid_g, mid_p;

  ks_bitgen #(.WIDTH(WIDTH)) u_bitgen (
    .a_i (a_i),
    .b_i (b_i),
    .g_o (bit_g),
    .p_o (bit_p)
  );

  ks_prefix_span #(.WIDTH(WIDTH), .LVL_FIRST(1), .LVL_LAST(SPLIT)) u_span_lo (
    .g_i (bit_g),
    .p_i (bit_p),
    .g_o (mid_g),
    .p_o (mid_p)
  );

  logic             s1_valid;
  logic [WIDTH-1:0] s1_g, s1_p, s1_half;
  logic             s1_cin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_valid <= 1'b0;
    else         s1_valid <= valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (valid_i) begin
      s1_g    <= mid_g;
      s1_p    <= mid_p;
      s1_half <= bit_p;
      s1_cin  <= cin_i;
    end
  end

  // stage 2
  logic [WIDTH-1:0] fin_g, fin_p;
  logic [WIDTH-1:0] sum_d;
  logic             cout_d;

  ks_prefix_span #(.WIDTH(WIDTH), .LVL_FIRST(SPLIT+1), .LVL_LAST(LEVELS)) u_span_hi (
    .g_i (s1_g),
    .p_i (s1_p),
    .g_o (fin_g),
    .p_o (fin_p)
  );

  ks_sum_gen #(.WIDTH(WIDTH)) u_sum (
    .grp_g_i (fin_g),
    .grp_p_i (fin_p),
    .half_i  (s1_half),
    .cin_i   (s1_cin),
    .sum_o   (sum_d),
    .cout_o  (cout_d)
  );

  logic             out_valid;
  logic [WIDTH-1:0] sum_q;
  logic             cout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid <= 1'b0;
    else         out_valid <= s1_valid;
  end

  always_ff @(posedge clk_i) begin
    if (s1_valid) begin
      sum_q  <= sum_d;
      cout_q <= cout_d;
    end
  end

  assign sum_o   = sum_q;
  assign cout_o  = cout_q;
  assign valid_o = out_valid;
endmodule

// File: rtl/ks_pipe_adder_chk.sv
module ks_pipe_adder_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             valid_o
);
  logic [1:0]       warm;
  logic [WIDTH-1:0] a_d1, a_d2, b_d1, b_d2;
  logic             c_d1, c_d2;
  logic [WIDTH:0]   ref_total;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  always_ff @(posedge clk_i) begin
    a_d1 <= a_i;  a_d2 <= a_d1;
    b_d1 <= b_i;  b_d2 <= b_d1;
    c_d1 <= cin_i; c_d2 <= c_d1;
  end

  assign ref_total = {1'b0, a_d2} + {1'b0, b_d2} + {{WIDTH{1'b0}}, c_d2};

  assert_sum_value_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == 2'd2 && valid_o) |-> sum_o == ref_total[WIDTH-1:0]);

  assert_carry_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == 2'd2 && valid_o) |-> cout_o == ref_total[WIDTH]);

  assert_valid_delay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == 2'd2) |-> valid_o == $past(valid_i, 2));

  assert_reset_clear_R6: assert property (@(posedge clk_i)
    !rst_ni |=> !valid_o);

  assert_hold_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == 2'd2 && !$past(valid_i, 2)) |-> ($stable(sum_o) && $stable(cout_o)));
endmodule

bind ks_pipe_adder ks_pipe_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .sum_o   (sum_o),
  .cout_o  (cout_o),
  .valid_o (valid_o)
);

// File: tb/ks_pipe_adder_tb_top.sv
module ks_pipe_adder_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         cin_i = 1'b0;
  logic [W-1:0] sum_o;
  logic         cout_o;
  logic         valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  ks_pipe_adder #(.WIDTH(W)) dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .valid_i (valid_i),
    .a_i (a_i), .b_i (b_i), .cin_i (cin_i),
    .sum_o (sum_o), .cout_o (cout_o), .valid_o (valid_o)
  );

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         cin;
    logic [W-1:0] sum;
    logic         cout;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h00000000, 32'h00000000, 1'b0, 32'h00000000, 1'b0},
    '{32'hFFFFFFFF, 32'h00000001, 1'b0, 32'h00000000, 1'b1},
    '{32'hFFFFFFFF, 32'h00000000, 1'b1, 32'h00000000, 1'b1},
    '{32'h00000000, 32'h00000000, 1'b1, 32'h00000001, 1'b0},
    '{32'h12345678, 32'h11111111, 1'b0, 32'h23456789, 1'b0},
    '{32'h80000000, 32'h80000000, 1'b0, 32'h00000000, 1'b1},
    '{32'hAAAAAAAA, 32'h55555555, 1'b0, 32'hFFFFFFFF, 1'b0},
    '{32'hAAAAAAAA, 32'h55555555, 1'b1, 32'h00000000, 1'b1},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF, 1'b1},
    '{32'h7FFFFFFF, 32'h00000001, 1'b0, 32'h80000000, 1'b0},
    '{32'hDEADBEEF, 32'h00000001, 1'b0, 32'hDEADBEF0, 1'b0},
    '{32'h0000FFFF, 32'h00000001, 1'b0, 32'h00010000, 1'b0},
    '{32'h89ABCDEF, 32'h76543210, 1'b1, 32'h00000000, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    valid_i = v; a_i = a; b_i = b; cin_i = c;
  endtask

  function automatic logic [W-1:0] xs(input logic [W-1:0] x);
    logic [W-1:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    #(8ns * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    logic         held_c;
    logic [W-1:0] ra [40];
    logic [W-1:0] rb [40];
    logic         rc [40];
    logic [W-1:0] seed;

    // reset state (R6)
    repeat (3) @(negedge clk_i);
    chk("R6 valid low in reset", 64'(valid_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R6 valid low after release", 64'(valid_o), 64'd0);
    @(negedge clk_i);
    chk("R6 valid low two cycles after release", 64'(valid_o), 64'd0);

    // table walk, back to back (R1 R2 R3 R5)
    for (int k = 0; k < NV + 2; k++) begin
      if (k >= 2) begin
        chk("R5 valid per cycle", 64'(valid_o), 64'd1);
        chk("R1 table sum", 64'(sum_o), 64'(VECS[k-2].sum));
        chk("R2 table cout", 64'(cout_o), 64'(VECS[k-2].cout));
        if (VECS[k-2].cin) chk("R3 carry-in at bit 0", 65'({cout_o, sum_o}), 65'({VECS[k-2].cout, VECS[k-2].sum}));
      end
      if (k < NV) drive(1'b1, VECS[k].a, VECS[k].b, VECS[k].cin);
      else        drive(1'b0, '0, '0, 1'b0);
      @(negedge clk_i);
    end

    // single pair latency (R4) and gap behaviour (R7 R8)
    drive(1'b1, 32'h00000F0F, 32'h000000F1, 1'b1);        // sum 00001001
    @(negedge clk_i);
    drive(1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
    chk("R4 no result after one edge", 64'(valid_o), 64'd0);
    @(negedge clk_i);
    drive(1'b1, 32'h40000000, 32'hC0000000, 1'b0);        // sum 0, cout 1
    chk("R4 result after two edges", 64'(valid_o), 64'd1);
    chk("R1 latency sum", 64'(sum_o), 64'h00001001);
    @(negedge clk_i);
    drive(1'b0, 32'h12121212, 32'h34343434, 1'b1);
    chk("R7 gap gives valid low", 64'(valid_o), 64'd0);
    chk("R8 sum held in gap", 64'(sum_o), 64'h00001001);
    chk("R8 cout held in gap", 64'(cout_o), 64'd0);
    @(negedge clk_i);
    chk("R7 result after gap valid", 64'(valid_o), 64'd1);
    chk("R7 result after gap sum", 65'({cout_o, sum_o}), 65'h1_00000000);
    @(negedge clk_i);
    chk("R4 valid drops after last pair", 64'(valid_o), 64'd0);

    // reset keeps data (R6 R8)
    held = sum_o; held_c = cout_o;
    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R6 valid low in second reset", 64'(valid_o), 64'd0);
    chk("R8 sum kept through reset", 65'({cout_o, sum_o}), 65'({held_c, held}));
    rst_ni = 1'b1;
    @(negedge clk_i);

    // pseudo-random stream against a behavioural sum (R1 R2 R5)
    seed = 32'h1D872B41;
    for (int k = 0; k < 40; k++) begin
      seed = xs(seed); ra[k] = seed;
      seed = xs(seed); rb[k] = seed;
      rc[k] = seed[7];
    end
    for (int k = 0; k < 42; k++) begin
      if (k >= 2) begin
        logic [W:0] tot;
        tot = {1'b0, ra[k-2]} + {1'b0, rb[k-2]} + {{W{1'b0}}, rc[k-2]};
        chk("R5 stream valid", 64'(valid_o), 64'd1);
        chk("R1 stream sum", 64'(sum_o), 64'(tot[W-1:0]));
        chk("R2 stream cout", 64'(cout_o), 64'(tot[W]));
      end
      if (k < 40) drive(1'b1, ra[k], rb[k], rc[k]);
      else        drive(1'b0, '0, '0, 1'b0);
      @(negedge clk_i);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule